// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

A purely combinational datapath slice that takes two operands and a carry-in and returns one result chosen from three sections: an adder, a bitwise logic stage, and a single-position shifter acting on operand A. A 4-bit select decides the outcome. Its upper two bits pick the section. Its lower two bits pick the operation inside the adder or the logic stage.

The adder has one fixed structure. Its second input comes, per bit, from B, the inverse of B, a row of zeros or a row of ones. Transfer, increment and decrement are therefore not separate circuits. They appear when the adder is fed zeros or ones and the carry-in is set accordingly. The carry out of the adder's top bit is presented only when the adder is the selected source. The width is a parameter, and the default is 8 bits.

There is no state machine and there are no registers. The block has one decode "state", the selected source, with four values: SRC_ARITH (select 00xx), SRC_LOGIC (01xx), SRC_SHR (10xx) and SRC_SHL (11xx). Any change of the select moves between them at once. There is no transition sequence.

Top module: `alsu_top`

## Requirements
- R1: The select bits sel_i[3:2] choose the source of f_o: 00 is the adder, 01 is the logic stage, 10 is A shifted right by one, and 11 is A shifted left by one.
- R2: With sel_i = 0000, the adder's second input is all zeros. {cout_o, f_o} = A + cin_i, so F = A when cin_i = 0 and F = A + 1 when cin_i = 1.
- R3: With sel_i = 0001, the adder's second input is all ones. {cout_o, f_o} = A + (2^W − 1) + cin_i, so F = A − 1 when cin_i = 0 and F = A when cin_i = 1.
- R4: With sel_i = 0010, {cout_o, f_o} = A + B + cin_i.
- R5: With sel_i = 0011, {cout_o, f_o} = A + ~B + cin_i, which is subtract with borrow.
- R6: With sel_i = 01xx, f_o is A AND B for xx = 00, A OR B for 01, A XOR B for 10, and ~A for 11. cin_i has no effect on the result.
- R7: With sel_i = 10xx, f_o = {0, A[W−1:1]}, so a 0 enters the most significant bit. sel_i[1:0] and cin_i have no effect on the result.
- R8: With sel_i = 11xx, f_o = {A[W−2:0], 0}, so a 0 enters the least significant bit. sel_i[1:0] and cin_i have no effect on the result.
- R9: cout_o is 0 whenever sel_i[3:2] is not 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A (also the shift source) |
| b_i | input | WIDTH | Operand B |
| cin_i | input | 1 | Carry-in to the adder |
| sel_i | input | 4 | Select: [3:2] source, [1:0] operation |
| f_o | output | WIDTH | Selected result |
| cout_o | output | 1 | Adder carry from the top bit; 0 for the logic stage and both shifts |

## Verification
The block holds no state, so an internal fault shows up in the same evaluation as the input that exposes it. Faults of this kind include a wrong decode of the section select, a swapped operand-mux leg, or a broken link in the carry chain. Each one gives a wrong f_o or cout_o for that select. It does not carry over to later inputs. A broken carry link appears only for operands that propagate a carry across it. For that reason the stimulus includes all-ones, zero and sign-bit patterns under every select and carry-in combination.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

    typedef enum logic [1:0] {
        SRC_ARITH = 2'b00,
        SRC_LOGIC = 2'b01,
        SRC_SHR   = 2'b10,
        SRC_SHL   = 2'b11
    } source_e;

    typedef enum logic [1:0] {
        YSEL_B     = 2'b00,
        YSEL_B_INV = 2'b01,
        YSEL_ZERO  = 2'b10,
        YSEL_ONES  = 2'b11
    } ysel_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_XOR = 2'b10,
        LOP_NOT = 2'b11
    } logic_op_e;

    // The low select bits 00,01,10,11 map to the adder's second input as 0,1s,B,~B.
    function automatic ysel_e arith_ysel(input logic [1:0] op);
        ysel_e r;
        unique case (op)
            2'b00:   r = YSEL_ZERO;
            2'b01:   r = YSEL_ONES;
            2'b10:   r = YSEL_B;
            default: r = YSEL_B_INV;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
    import alsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam int CHAIN = WIDTH + 1;

    ysel_e            ysel;
    logic [WIDTH-1:0] y_bits;
    logic [CHAIN-1:0] carry;

    assign ysel     = arith_ysel(op_i);
    assign carry[0] = cin_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (ysel)
                YSEL_B:     y_bits[i] = b_i[i];
                YSEL_B_INV: y_bits[i] = ~b_i[i];
                YSEL_ZERO:  y_bits[i] = 1'b0;
                YSEL_ONES:  y_bits[i] = 1'b1;
                default:    y_bits[i] = 1'b0;
            endcase
        end
        assign sum_o[i]   = a_i[i] ^ y_bits[i] ^ carry[i];
        assign carry[i+1] = (a_i[i] & y_bits[i]) | (carry[i] & (a_i[i] ^ y_bits[i]));
    end

    assign cout_o = carry[CHAIN-1];

    // Ripple chain checked against a wide reference add for the B-based ops
    always_comb begin
        if (op_i == 2'b10) begin
            p_add_carry_r4: assert ({cout_o, sum_o} ==
                ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
                else $error("adder sum mismatch");
        end
        if (op_i == 2'b11) begin
            p_sub_borrow_r5: assert ({cout_o, sum_o} ==
                ({1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, cin_i}))
                else $error("subtract sum mismatch");
        end
    end

endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
    import alsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] res_o
);

    logic_op_e lop;
    assign lop = logic_op_e'(op_i);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (lop)
                LOP_AND: res_o[i] = a_i[i] & b_i[i];
                LOP_OR:  res_o[i] = a_i[i] | b_i[i];
                LOP_XOR: res_o[i] = a_i[i] ^ b_i[i];
                LOP_NOT: res_o[i] = ~a_i[i];
                default: res_o[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    output logic [WIDTH-1:0] shr_o,
    output logic [WIDTH-1:0] shl_o
);

    localparam int TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == TOP) begin : g_top
            assign shr_o[i] = 1'b0;
        end else begin : g_mid_r
            assign shr_o[i] = a_i[i+1];
        end
        if (i == 0) begin : g_low
            assign shl_o[i] = 1'b0;
        end else begin : g_mid_l
            assign shl_o[i] = a_i[i-1];
        end
    end

endmodule

// File: rtl/alsu_top.sv
module alsu_top
    import alsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    input  logic [3:0]       sel_i,
    output logic [WIDTH-1:0] f_o,
    output logic             cout_o
);

    source_e          src;
    logic [WIDTH-1:0] arith_res;
    logic             arith_cout;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] shr_res;
    logic [WIDTH-1:0] shl_res;

    assign src = source_e'(sel_i[3:2]);

    alsu_arith #(.WIDTH(WIDTH)) u_arith (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .op_i   (sel_i[1:0]),
        .sum_o  (arith_res),
        .cout_o (arith_cout)
    );

    alsu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (sel_i[1:0]),
        .res_o (logic_res)
    );

    alsu_shift #(.WIDTH(WIDTH)) u_shift (
        .a_i   (a_i),
        .shr_o (shr_res),
        .shl_o (shl_res)
    );

    always_comb begin
        unique case (src)
            SRC_ARITH: begin
                f_o    = arith_res;
                cout_o = arith_cout;
            end
            SRC_LOGIC: begin
                f_o    = logic_res;
                cout_o = 1'b0;
            end
            SRC_SHR: begin
                f_o    = shr_res;
                cout_o = 1'b0;
            end
            SRC_SHL: begin
                f_o    = shl_res;
                cout_o = 1'b0;
            end
            default: begin
                f_o    = '0;
                cout_o = 1'b0;
            end
        endcase
    end

    // Port-level checks next to the source mux
    always_comb begin
        if (sel_i[3] | sel_i[2]) begin
            p_no_carry_r9: assert (cout_o == 1'b0) else $error("carry outside adder");
        end
        if (sel_i[3:2] == 2'b10) begin
            p_shr_fill_r7: assert (f_o == (a_i >> 1)) else $error("shift right wrong");
        end
        if (sel_i[3:2] == 2'b11) begin
            p_shl_fill_r8: assert (f_o == (a_i << 1)) else $error("shift left wrong");
        end
        if (sel_i == 4'b0111) begin
            p_not_a_r6: assert (f_o == ~a_i) else $error("complement wrong");
        end
        if (sel_i == 4'b0000 && !cin_i) begin
            p_transfer_r2: assert (f_o == a_i && !cout_o) else $error("transfer wrong");
        end
        if (sel_i == 4'b0001 && cin_i) begin
            p_transfer_ones_r3: assert (f_o == a_i) else $error("transfer via ones wrong");
        end
    end

endmodule

// File: tb/alsu_top_bench.sv
`timescale 1ns/1ps
module alsu_top_bench;

    localparam int W = 8;

    typedef struct {
        logic [W:0] exp;
        string      tag;
        logic [3:0] sel;
        logic       cin;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         cin_i = 1'b0;
    logic [3:0]   sel_i = 4'b0000;
    logic [W-1:0] f_o;
    logic         cout_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    item_t sb[$];

    always #5 clk = ~clk;

    alsu_top #(.WIDTH(W)) u_alsu_top (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .sel_i  (sel_i),
        .f_o    (f_o),
        .cout_o (cout_o)
    );

    function automatic logic [W:0] ref_model(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic c, input logic [3:0] s);
        logic [W:0] r;
        case (s[3:2])
            2'b00: begin
                case (s[1:0])
                    2'b00: r = {1'b0, a} + {{W{1'b0}}, c};                       // R2
                    2'b01: r = {1'b0, a} + {1'b0, {W{1'b1}}} + {{W{1'b0}}, c};   // R3
                    2'b10: r = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};           // R4
                    default: r = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, c};        // R5
                endcase
            end
            2'b01: begin
                case (s[1:0])
                    2'b00: r = {1'b0, a & b};
                    2'b01: r = {1'b0, a | b};
                    2'b10: r = {1'b0, a ^ b};
                    default: r = {1'b0, ~a};
                endcase
            end
            2'b10:   r = {1'b0, 1'b0, a[W-1:1]};
            default: r = {1'b0, a[W-2:0], 1'b0};
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [3:0] s);
        case (s[3:2])
            2'b00: begin
                case (s[1:0])
                    2'b00: return "R1 R2";
                    2'b01: return "R1 R3";
                    2'b10: return "R1 R4";
                    default: return "R1 R5";
                endcase
            end
            2'b01:   return "R1 R6 R9";
            2'b10:   return "R1 R7 R9";
            default: return "R1 R8 R9";
        endcase
    endfunction

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic c, input logic [3:0] s, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        a_i   = a;
        b_i   = b;
        cin_i = c;
        sel_i = s;
        it.exp = ref_model(a, b, c, s);
        it.tag = tag;
        it.sel = s;
        it.cin = c;
        it.a   = a;
        it.b   = b;
        sb.push_back(it);
    endtask

    // Monitor: compare on the falling edge, half a cycle after each drive
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_checks++;
                if ({cout_o, f_o} !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s sel=%b cin=%b a=%h b=%h : actual cout=%b f=%h expected cout=%b f=%h",
                             it.tag, it.sel, it.cin, it.a, it.b, cout_o, f_o, it.exp[W], it.exp[W-1:0]);
                end
            end
        end
    end

    initial begin
        logic [W-1:0] edges [7];
        edges[0] = '0;
        edges[1] = '1;
        edges[2] = {1'b1, {(W-1){1'b0}}};
        edges[3] = {1'b0, {(W-1){1'b1}}};
        edges[4] = {{(W-1){1'b0}}, 1'b1};
        edges[5] = {(W/2){2'b01}};
        edges[6] = {(W/2){2'b10}};

        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset-state check: idle inputs give transfer of zero (R2)
        drive('0, '0, 1'b0, 4'b0000, "R2 reset");

        // Named corner cases
        drive(8'hFF, 8'h00, 1'b1, 4'b0000, "R2 increment wrap");
        drive(8'h00, 8'h00, 1'b0, 4'b0001, "R3 decrement of zero");
        drive(8'h00, 8'h00, 1'b1, 4'b0001, "R3 transfer via ones");
        drive(8'hFF, 8'h01, 1'b0, 4'b0010, "R4 carry ripple");
        drive(8'h05, 8'h05, 1'b1, 4'b0011, "R5 equal subtract");
        drive(8'h05, 8'h06, 1'b1, 4'b0011, "R5 borrow");
        drive(8'hA5, 8'h0F, 1'b1, 4'b0111, "R6 not ignores cin");
        drive(8'h81, 8'hFF, 1'b1, 4'b1011, "R7 msb fill zero");
        drive(8'h81, 8'hFF, 1'b1, 4'b1110, "R8 lsb fill zero");
        drive(8'hFF, 8'hFF, 1'b1, 4'b0101, "R9 no carry in logic");

        // Every select and carry-in over the edge operands
        for (int ia = 0; ia < 7; ia++) begin
            for (int ib = 0; ib < 7; ib++) begin
                for (int s = 0; s < 16; s++) begin
                    for (int c = 0; c < 2; c++) begin
                        drive(edges[ia], edges[ib], c[0], s[3:0], tag_of(s[3:0]));
                    end
                end
            end
        end

        // Random operands, every select and carry-in
        for (int k = 0; k < 25; k++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = W'($urandom());
            rb = W'($urandom());
            for (int s = 0; s < 16; s++) begin
                for (int c = 0; c < 2; c++) begin
                    drive(ra, rb, c[0], s[3:0], tag_of(s[3:0]));
                end
            end
        end

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule